// File: doc/BRIEF.md
# Compare-Value Timer with Downcount View

This block is a single timer channel that sits beside a shared, free-running 64-bit count. Software programs an absolute 64-bit deadline in a compare register, or it writes a signed 32-bit relative interval. The block adds that interval to the current count and stores the sum as the new deadline. Reading the interval view returns the low 32 bits of the time left before the deadline, so the view behaves like a 32-bit down-counter. That view holds no storage of its own. It is computed from the compare register and the live count, so it keeps moving while the timer is switched off.

Once enabled, the timer raises a status flag when the count has reached or passed the deadline. The flag is judged as a signed 64-bit difference, so it behaves correctly across wrap of the count. An interrupt line follows the status flag unless a mask bit is set. Every register access is also checked against the caller's privilege level and security state. A refused access is reported either as undefined or as a trap to the highest level with a fixed class code. A refused access changes nothing and reads as zero.

Top module: `cmp_timer`

## Requirements
- R1: After reset the compare register is 0, the control register reads 0 (enable 0, mask 0), and status_o and irq_o are 0.
- R2: Selector 1 is the 64-bit compare register: a permitted write stores all 64 bits, and a permitted read returns them.
- R3: Selector 2 is the interval view. A permitted read with enable set returns the low 32 bits of (compare - count), zero-extended to 64 bits. With enable clear it returns 0.
- R4: A permitted write to selector 2 sets compare to count plus wdata[31:0] sign-extended to 64 bits. wdata[63:32] has no effect.
- R5: status_o is 1 exactly when enable is 1 and (count - compare), taken as a signed 64-bit value, is at least zero. Control bit 2 reads this status and is read-only.
- R6: Selector 0 is control, with bit 0 as enable and bit 1 as mask. Other bits read 0. irq_o = status_o AND NOT mask.
- R7: The interval view keeps counting down while enable is 0. After enable is set, a read reflects all elapsed count, including the disabled time.
- R8: Accesses at privilege level 0 or 2 assert undef_o. Accesses at level 3 are always permitted.
- R9: At level 1, the access is undefined when nonsecure_i is 1 or sec_l2_en_i is 1. Otherwise, if sec_access_en_i is 0, it asserts trap_o with trap_class_o = 0x18. Otherwise it is permitted.
- R10: undef_o and trap_o are never both set and appear only in a cycle where acc_valid_i is 1. A refused access returns rdata_o = 0 and leaves all register state unchanged. Selector 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | 64 | Shared free-running count |
| acc_valid_i | input | 1 | Access strobe, one cycle per access |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_sel_i | input | 2 | 0 control, 1 compare, 2 interval view, 3 unused |
| acc_wdata_i | input | 64 | Write data |
| priv_level_i | input | 2 | Privilege level of the caller, 0..3 |
| nonsecure_i | input | 1 | Caller is in non-secure state |
| sec_l2_en_i | input | 1 | Secure level 2 is enabled by the top level |
| sec_access_en_i | input | 1 | Top level lets secure level 1 use this timer |
| rdata_o | output | 64 | Read data, valid in the strobe cycle |
| status_o | output | 1 | Timer condition met while enabled |
| irq_o | output | 1 | Interrupt request |
| undef_o | output | 1 | Access reported as undefined |
| trap_o | output | 1 | Access reported as a trap to level 3 |
| trap_class_o | output | 6 | Trap class code, 0x18 during a trap, else 0 |

## Verification
The hardest situation to reach is a deadline placed across the count's wrap point with the status decision resting on the sign of the 64-bit difference. The bench forces it by driving the count input directly to values a few ticks below 2^64 and then writing interval values at the signed extremes. A second hard case is a refused write that must leave state intact. The bench covers it by sweeping all 32 combinations of level and security inputs, attempting a write under each, and reading back from level 3.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int CNT_W = 64,
  parameter int TV_W  = 32,
  parameter int EC_W  = 6,
  parameter logic [EC_W-1:0] TRAP_CLASS = 6'h18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             acc_valid_i,
  input  logic             acc_write_i,
  input  logic [1:0]       acc_sel_i,
  input  logic [CNT_W-1:0] acc_wdata_i,
  input  logic [1:0]       priv_level_i,
  input  logic             nonsecure_i,
  input  logic             sec_l2_en_i,
  input  logic             sec_access_en_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             status_o,
  output logic             irq_o,
  output logic             undef_o,
  output logic             trap_o,
  output logic [EC_W-1:0]  trap_class_o
);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CMP  = 2'd1;
  localparam logic [1:0] SEL_TVAL = 2'd2;
  localparam int EXT_W = CNT_W - TV_W;

  logic             enable_q;
  logic             imask_q;
  logic [CNT_W-1:0] cmp_q;

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] reload;
  logic             deny_undef;
  logic             deny_trap;
  logic             granted;
  logic             wr_en;

  assign remain  = cmp_q - count_i;
  assign elapsed = count_i - cmp_q;
  assign reload  = count_i + {{EXT_W{acc_wdata_i[TV_W-1]}}, acc_wdata_i[TV_W-1:0]};

  assign status_o = enable_q & ~elapsed[CNT_W-1];
  assign irq_o    = status_o & ~imask_q;

  always_comb begin
    deny_undef = 1'b0;
    deny_trap  = 1'b0;
    unique case (priv_level_i)
      2'd0, 2'd2: deny_undef = 1'b1;
      2'd1: begin
        if (nonsecure_i || sec_l2_en_i) deny_undef = 1'b1;
        else if (!sec_access_en_i)      deny_trap  = 1'b1;
      end
      default: ;
    endcase
  end

  assign undef_o      = acc_valid_i & deny_undef;
  assign trap_o       = acc_valid_i & deny_trap;
  assign trap_class_o = trap_o ? TRAP_CLASS : '0;
  assign granted      = acc_valid_i & ~deny_undef & ~deny_trap;
  assign wr_en        = granted & acc_write_i;

  always_comb begin
    rdata_o = '0;
    if (granted && !acc_write_i) begin
      unique case (acc_sel_i)
        SEL_CTRL: rdata_o[2:0] = {status_o, imask_q, enable_q};
        SEL_CMP:  rdata_o = cmp_q;
        SEL_TVAL: if (enable_q) rdata_o[TV_W-1:0] = remain[TV_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      imask_q  <= 1'b0;
      cmp_q    <= '0;
    end else if (wr_en) begin
      unique case (acc_sel_i)
        SEL_CTRL: begin
          enable_q <= acc_wdata_i[0];
          imask_q  <= acc_wdata_i[1];
        end
        SEL_CMP:  cmp_q <= acc_wdata_i;
        SEL_TVAL: cmp_q <= reload;
        default: ;
      endcase
    end
  end
endmodule

module cmp_timer_chk #(
  parameter int CNT_W = 64,
  parameter int TV_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count_i,
  input logic             acc_valid_i,
  input logic             acc_write_i,
  input logic [1:0]       acc_sel_i,
  input logic [CNT_W-1:0] acc_wdata_i,
  input logic [1:0]       priv_level_i,
  input logic [CNT_W-1:0] rdata_o,
  input logic             status_o,
  input logic             irq_o,
  input logic             undef_o,
  input logic             trap_o,
  input logic             enable_q,
  input logic             imask_q,
  input logic [CNT_W-1:0] cmp_q
);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(undef_o && trap_o));
  a_r10_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_o || trap_o) |-> acc_valid_i);
  a_r10_refused_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_o || trap_o) |-> rdata_o == '0);
  a_r10_refused_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_o || trap_o) |=> ($stable(cmp_q) && $stable(enable_q) && $stable(imask_q)));
  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_o && !imask_q));
  a_r5_status_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    status_o |-> enable_q);
  a_r8_level3_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && priv_level_i == 2'd3) |-> !(undef_o || trap_o));
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && acc_write_i && acc_sel_i == 2'd2 && !undef_o && !trap_o) |=>
      cmp_q == $past(count_i) + {{(CNT_W-TV_W){$past(acc_wdata_i[TV_W-1])}}, $past(acc_wdata_i[TV_W-1:0])});
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W), .TV_W(TV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count_i(count_i), .acc_valid_i(acc_valid_i),
  .acc_write_i(acc_write_i), .acc_sel_i(acc_sel_i), .acc_wdata_i(acc_wdata_i),
  .priv_level_i(priv_level_i), .rdata_o(rdata_o), .status_o(status_o),
  .irq_o(irq_o), .undef_o(undef_o), .trap_o(trap_o), .enable_q(enable_q),
  .imask_q(imask_q), .cmp_q(cmp_q)
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] count_i;
  logic        acc_valid_i, acc_write_i;
  logic [1:0]  acc_sel_i;
  logic [63:0] acc_wdata_i;
  logic [1:0]  priv_level_i;
  logic        nonsecure_i, sec_l2_en_i, sec_access_en_i;
  logic [63:0] rdata_o;
  logic        status_o, irq_o, undef_o, trap_o;
  logic [5:0]  trap_class_o;

  int checks = 0;
  int fails  = 0;
  logic [63:0] rd;
  logic        un, tr;
  logic [5:0]  ec;

  always #5 clk = ~clk;

  cmp_timer u_cmp_timer (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [1:0] sel, input logic [63:0] wd);
    @(negedge clk);
    acc_valid_i = 1'b1; acc_write_i = wr; acc_sel_i = sel; acc_wdata_i = wd;
    #1;
    rd = rdata_o; un = undef_o; tr = trap_o; ec = trap_class_o;
    @(posedge clk);
    #1;
    acc_valid_i = 1'b0; acc_write_i = 1'b0;
  endtask

  task automatic set_priv(input logic [1:0] lv, input logic ns, input logic l2, input logic st);
    priv_level_i = lv; nonsecure_i = ns; sec_l2_en_i = l2; sec_access_en_i = st;
  endtask

  function automatic logic [63:0] sext(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  task automatic check_timer(input string req, input logic [63:0] cmp, input logic en, input logic msk);
    logic [63:0] diff;
    logic st;
    #1;
    diff = count_i - cmp;
    st = en && ($signed(diff) >= 0);
    check({req, " status"}, {63'd0, status_o}, {63'd0, st});
    check({req, " irq R6"}, {63'd0, irq_o}, {63'd0, st && !msk});
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] cmp_exp;
    logic [63:0] counts [3];
    logic [31:0] tvs [6];
    counts = '{64'd0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0001_7FFF_FFFF};
    tvs = '{32'd0, 32'd1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'd5};
    rst_n = 1'b0; count_i = 64'd1000;
    acc_valid_i = 0; acc_write_i = 0; acc_sel_i = 0; acc_wdata_i = 0;
    set_priv(2'd3, 1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    check("R1 status", {63'd0, status_o}, 64'd0);
    check("R1 irq", {63'd0, irq_o}, 64'd0);
    rst_n = 1'b1;
    acc(0, 2'd0, 0); check("R1 ctrl", rd, 64'd0);
    acc(0, 2'd1, 0); check("R1 compare", rd, 64'd0);

    acc(1, 2'd1, 64'h0123_4567_89AB_CDEF);
    acc(0, 2'd1, 0); check("R2 compare rw", rd, 64'h0123_4567_89AB_CDEF);

    acc(0, 2'd2, 0); check("R3 disabled read", rd, 64'd0);
    acc(1, 2'd3, 64'hFFFF); acc(0, 2'd3, 0); check("R10 sel3", rd, 64'd0);

    for (int m = 0; m < 2; m++) begin
      acc(1, 2'd0, {62'd0, m[0], 1'b1});
      for (int c = 0; c < 3; c++) begin
        for (int t = 0; t < 6; t++) begin
          count_i = counts[c];
          acc(1, 2'd2, {32'hDEAD_BEEF, tvs[t]});
          cmp_exp = counts[c] + sext(tvs[t]);
          acc(0, 2'd1, 0); check("R4 reload", rd, cmp_exp);
          acc(0, 2'd2, 0); check("R3 view", rd, {32'd0, tvs[t]});
          check_timer("R5", cmp_exp, 1'b1, m[0]);
          count_i = counts[c] + 64'd3;
          acc(0, 2'd2, 0); check("R3 countdown", rd, {32'd0, tvs[t] - 32'd3});
          check_timer("R5 later", cmp_exp, 1'b1, m[0]);
          acc(0, 2'd0, 0);
          check("R5 ctrl status", rd, {61'd0, status_o, m[0], 1'b1});
        end
      end
    end

    acc(1, 2'd0, 64'h7);
    acc(0, 2'd0, 0); check("R6 ctrl write", rd[1:0], 64'd3);
    check("R5 istatus ro", {63'd0, rd[2]}, {63'd0, status_o});

    acc(1, 2'd0, 64'd0);
    count_i = 64'd5000;
    acc(1, 2'd2, 64'd100);
    check_timer("R5 disabled", 64'd5100, 1'b0, 1'b0);
    count_i = 64'd5030;
    acc(0, 2'd2, 0); check("R3 disabled zero", rd, 64'd0);
    acc(1, 2'd0, 64'd1);
    acc(0, 2'd2, 0); check("R7 elapsed", rd, 64'd70);
    count_i = 64'd5150;
    acc(0, 2'd2, 0); check("R7 past", rd, {32'd0, 32'hFFFF_FFCE});
    check_timer("R7 fire", 64'd5100, 1'b1, 1'b0);

    for (int k = 0; k < 32; k++) begin
      logic [1:0] lv;
      logic ns, l2, st, eu, et;
      lv = k[4:3]; ns = k[2]; l2 = k[1]; st = k[0];
      eu = (lv == 2'd0) || (lv == 2'd2) || (lv == 2'd1 && (ns || l2));
      et = (lv == 2'd1) && !ns && !l2 && !st;
      set_priv(2'd3, 0, 0, 0);
      acc(1, 2'd1, 64'hAAAA_0000_0000_0000 + 64'(k));
      set_priv(lv, ns, l2, st);
      acc(0, 2'd1, 0);
      check(lv == 2'd1 ? "R9 undef" : "R8 undef", {63'd0, un}, {63'd0, eu});
      check("R9 trap", {63'd0, tr}, {63'd0, et});
      check("R9 class", {58'd0, ec}, et ? 64'h18 : 64'd0);
      check("R10 rdata", rd, (eu || et) ? 64'd0 : 64'hAAAA_0000_0000_0000 + 64'(k));
      acc(1, 2'd1, 64'h5555);
      set_priv(2'd3, 0, 0, 0);
      acc(0, 2'd1, 0);
      check("R10 state", rd, (eu || et) ? 64'hAAAA_0000_0000_0000 + 64'(k) : 64'h5555);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule